// File: doc/BRIEF.md
# Digitizer Channel Acquisition Run Controller

This block decides when one waveform-digitizer channel may store samples. Operators or a host computer start, stop, pause and clear a run. Each of the three events (start, stop, clear) can come from a front-panel input, which acts on its rising edge, or from a one-shot command bit that the host writes. A veto level, from a front-panel line or from a stored host bit, pauses storage. The timestamp counter keeps counting while the veto is active.

A three-state machine holds the run state. `ST_IDLE` is stopped. `ST_RUN` is acquiring. `ST_INHIBIT` is acquiring but vetoed. The transitions are:
- go: `ST_IDLE` to `ST_RUN`, or to `ST_INHIBIT` when the veto is active.
- halt: `ST_RUN` or `ST_INHIBIT` to `ST_IDLE`.
- veto-on: `ST_RUN` to `ST_INHIBIT`.
- veto-off: `ST_INHIBIT` to `ST_RUN`.
- clear: any state to `ST_IDLE`.

The block grants writes to the sample packer and advances a wrapping memory write pointer. It keeps a free-running timestamp, a saturating count of runs started and two sticky error flags. It also drives the digital comparator threshold code and the zero-suppression enable toward the front end.

The host reads and writes four word registers through a simple synchronous port. Reads are combinational.

Top module: `acq_run_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, the block holds these values: state `ST_IDLE`, `wr_ptr` 0, `time_cnt` 0, run count 0, both error flags 0, threshold 0, suppression off, software veto off, and `wr_en` low.
- R2: A go event moves `ST_IDLE` to `ST_RUN` at the next clock edge, or to `ST_INHIBIT` if the veto level is high. A go event is a rising edge of `fp_start`, or a write to CTRL (address 0) with bit 0 set. Each such move adds one to the run count in STATUS bits [16 +: CW]. The count saturates at 2^CW-1.
- R3: A halt event returns `ST_RUN` or `ST_INHIBIT` to `ST_IDLE` at the next edge. A halt event is a rising edge of `fp_stop`, or a CTRL write with bit 1 set. When a go event and a halt event fall in the same cycle, halt wins.
- R4: `wr_en` equals `data_valid` only while all of these hold: the state is `ST_RUN` or `ST_INHIBIT`, the veto level (`fp_veto` OR CTRL bit 3) is low, and no clear event is present. In every other case `wr_en` is 0. Veto high moves `ST_RUN` to `ST_INHIBIT`. Veto low moves `ST_INHIBIT` back to `ST_RUN`.
- R5: `time_cnt` increases by one, modulo 2^TW, on every clock that has no clear event. Run state and veto do not affect it.
- R6: A clear event drives `cnt_clr` high in the same cycle. A clear event is a rising edge of `fp_reset`, or a CTRL write with bit 2 set. At the next edge the clear zeroes `time_cnt`, `wr_ptr`, the run count and both error flags, and it forces `ST_IDLE`. It takes priority over a go or halt event in the same cycle. It leaves the threshold, suppression and software veto settings unchanged.
- R7: `wr_ptr` advances by one on each cycle with `wr_en` high. It wraps from DEPTH-1 to 0, and that wrap sets the error flag in STATUS bit 4.
- R8: A go event without a halt or clear event, while the state is `ST_RUN` or `ST_INHIBIT`, sets the error flag in STATUS bit 5. The run count does not change.
- R9: Both error flags stay set until cleared. A STATUS write with bit 4 or bit 5 set clears the matching flag, and so does a clear event. If a flag is set and write-cleared in the same cycle, it stays set.
- R10: Every CTRL write stores bit 3 (software veto), bit 4 (`supp_en`) and bits [8 +: THW] (`thresh`). These drive their outputs from the next cycle and read back from CTRL. Bits 0 to 2 always read as 0.
- R11: `reg_rdata` shows the register selected by `reg_addr` in the same cycle:
  - 0 is CTRL.
  - 1 is STATUS, with the state in bits [1:0] coded IDLE=0, RUN=1, INHIBIT=2, the flags in bits 4 and 5, and the run count from bit 16.
  - 2 is `wr_ptr`.
  - 3 is `time_cnt`.

  Unused bits read as 0.
- R12: The front-panel start, stop and reset inputs act on rising edges only. Holding one of them high yields a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_start | input | 1 | Front-panel start, rising edge |
| fp_stop | input | 1 | Front-panel stop, rising edge |
| fp_veto | input | 1 | Front-panel veto level |
| fp_reset | input | 1 | Front-panel clear, rising edge |
| data_valid | input | 1 | Packer has a word to store |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data |
| wr_en | output | 1 | Write grant to packer and memory |
| wr_ptr | output | PW | Memory write address |
| time_cnt | output | TW | Timestamp counter |
| cnt_clr | output | 1 | Clear pulse for downstream counters |
| supp_en | output | 1 | Zero-suppression enable |
| thresh | output | THW | Comparator threshold code |

## Verification
Assertions check the following on every cycle:
- the write grant against the veto level and the run state;
- the one-step advance and the wrap of the write pointer;
- the timestamp increment;
- the effect of a clear;
- halt priority;
- the stickiness of the error flags;
- the run count step.

Only the bench scenarios can show certain ordered behaviours. These are:
- the single event from a held front-panel line;
- run-count saturation after many runs;
- a set and a clear of a flag in the same cycle;
- a go that reaches `ST_INHIBIT` because the veto was already high;
- settings surviving a clear;
- the register read map.

The reference model compares every output on every clock.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_INHIBIT = 2'd2
    } run_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_WPTR = 2'd2;
    localparam logic [1:0] A_TIME = 2'd3;

    localparam int B_GO     = 0;
    localparam int B_HALT   = 1;
    localparam int B_CLR    = 2;
    localparam int B_VETO   = 3;
    localparam int B_SUPP   = 4;
    localparam int B_THR_LO = 8;
    localparam int B_EWRAP  = 4;
    localparam int B_ERST   = 5;
    localparam int B_CYC_LO = 16;

    localparam int NEV = 3;

endpackage

// File: rtl/acq_evt_front.sv
module acq_evt_front
    import acq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fp_start,
    input  logic fp_stop,
    input  logic fp_reset,
    input  logic sw_go,
    input  logic sw_halt,
    input  logic sw_clr,
    output logic ev_go,
    output logic ev_halt,
    output logic ev_clr
);

    logic [NEV-1:0] fp_vec;
    logic [NEV-1:0] fp_q;
    logic [NEV-1:0] sw_vec;
    logic [NEV-1:0] ev_vec;

    assign fp_vec = {fp_reset, fp_stop, fp_start};
    assign sw_vec = {sw_clr, sw_halt, sw_go};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fp_q <= '0;
        else        fp_q <= fp_vec;
    end

    for (genvar i = 0; i < NEV; i++) begin : g_edge
        assign ev_vec[i] = (fp_vec[i] & ~fp_q[i]) | sw_vec[i];
    end

    assign ev_go   = ev_vec[0];
    assign ev_halt = ev_vec[1];
    assign ev_clr  = ev_vec[2];

endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
    import acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_go,
    input  logic       ev_halt,
    input  logic       ev_clr,
    input  logic       veto,
    output run_state_e st,
    output logic       active,
    output logic       cyc_inc,
    output logic       restart
);

    run_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (!ev_clr && ev_go && !ev_halt)
                    nxt = veto ? ST_INHIBIT : ST_RUN;
            end
            ST_RUN: begin
                if (ev_clr || ev_halt) nxt = ST_IDLE;
                else if (veto)         nxt = ST_INHIBIT;
            end
            ST_INHIBIT: begin
                if (ev_clr || ev_halt) nxt = ST_IDLE;
                else if (!veto)        nxt = ST_RUN;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        active  = (st != ST_IDLE);
        cyc_inc = (st == ST_IDLE) && ev_go && !ev_halt && !ev_clr;
        restart = (st != ST_IDLE) && ev_go && !ev_halt && !ev_clr;
    end

endmodule

// File: rtl/acq_counters.sv
module acq_counters #(
    parameter int DEPTH = 4096,
    parameter int TW    = 16,
    parameter int CW    = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          cyc_inc,
    output logic [PW-1:0] wr_ptr,
    output logic [TW-1:0] time_cnt,
    output logic [CW-1:0] cyc_cnt,
    output logic          wrap_hit
);

    localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CYCMAX = {CW{1'b1}};

    assign wrap_hit = wr_en && (wr_ptr == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   time_cnt <= '0;
        else if (clr) time_cnt <= '0;
        else          time_cnt <= time_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (clr)   wr_ptr <= '0;
        else if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cyc_cnt <= '0;
        else if (clr)                        cyc_cnt <= '0;
        else if (cyc_inc && cyc_cnt != CYCMAX) cyc_cnt <= cyc_cnt + 1'b1;
    end

endmodule

// File: rtl/acq_regs.sv
module acq_regs
    import acq_pkg::*;
#(
    parameter int THW = 8,
    parameter int PW  = 12,
    parameter int TW  = 16,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [1:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    input  run_state_e     st,
    input  logic           clr_evt,
    input  logic           set_wrap,
    input  logic           set_restart,
    input  logic [PW-1:0]  wr_ptr,
    input  logic [TW-1:0]  time_cnt,
    input  logic [CW-1:0]  cyc_cnt,
    output logic           sw_go,
    output logic           sw_halt,
    output logic           sw_clr,
    output logic           sw_veto,
    output logic           supp_en,
    output logic [THW-1:0] thresh,
    output logic [1:0]     err_q,
    output logic [1:0]     err_clr,
    output logic [31:0]    reg_rdata
);

    logic ctrl_wr;
    logic stat_wr;
    logic unused_wdata;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign stat_wr = reg_wr && (reg_addr == A_STAT);

    assign sw_go   = ctrl_wr && reg_wdata[B_GO];
    assign sw_halt = ctrl_wr && reg_wdata[B_HALT];
    assign sw_clr  = ctrl_wr && reg_wdata[B_CLR];

    assign err_clr = stat_wr ? reg_wdata[B_ERST:B_EWRAP] : 2'b00;

    assign unused_wdata = ^{reg_wdata[31:B_THR_LO+THW], reg_wdata[B_THR_LO-1:B_ERST+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_veto <= 1'b0;
            supp_en <= 1'b0;
            thresh  <= '0;
        end else if (ctrl_wr) begin
            sw_veto <= reg_wdata[B_VETO];
            supp_en <= reg_wdata[B_SUPP];
            thresh  <= reg_wdata[B_THR_LO +: THW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_q <= 2'b00;
        else if (clr_evt) err_q <= 2'b00;
        else              err_q <= (err_q & ~err_clr) | {set_restart, set_wrap};
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_VETO]            = sw_veto;
                reg_rdata[B_SUPP]            = supp_en;
                reg_rdata[B_THR_LO +: THW]   = thresh;
            end
            A_STAT: begin
                reg_rdata[1:0]               = st;
                reg_rdata[B_EWRAP]           = err_q[0];
                reg_rdata[B_ERST]            = err_q[1];
                reg_rdata[B_CYC_LO +: CW]    = cyc_cnt;
            end
            A_WPTR:  reg_rdata[PW-1:0]       = wr_ptr;
            A_TIME:  reg_rdata[TW-1:0]       = time_cnt;
            default: reg_rdata               = '0;
        endcase
    end

endmodule

// File: rtl/acq_run_ctrl.sv
module acq_run_ctrl
    import acq_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int TW    = 16,
    parameter int CW    = 16,
    parameter int THW   = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fp_start,
    input  logic           fp_stop,
    input  logic           fp_veto,
    input  logic           fp_reset,
    input  logic           data_valid,
    input  logic           reg_wr,
    input  logic [1:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           wr_en,
    output logic [PW-1:0]  wr_ptr,
    output logic [TW-1:0]  time_cnt,
    output logic           cnt_clr,
    output logic           supp_en,
    output logic [THW-1:0] thresh
);

    logic       sw_go, sw_halt, sw_clr, sw_veto;
    logic       ev_go, ev_halt, ev_clr;
    logic       veto_lvl;
    logic       active, cyc_inc, restart, wrap_hit;
    logic [1:0] err_q, err_clr;
    logic [CW-1:0] cyc_cnt;
    run_state_e st;

    assign veto_lvl = fp_veto | sw_veto;
    assign cnt_clr  = ev_clr;
    assign wr_en    = data_valid && active && !veto_lvl && !ev_clr;

    acq_evt_front u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fp_start (fp_start),
        .fp_stop  (fp_stop),
        .fp_reset (fp_reset),
        .sw_go    (sw_go),
        .sw_halt  (sw_halt),
        .sw_clr   (sw_clr),
        .ev_go    (ev_go),
        .ev_halt  (ev_halt),
        .ev_clr   (ev_clr)
    );

    acq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_go   (ev_go),
        .ev_halt (ev_halt),
        .ev_clr  (ev_clr),
        .veto    (veto_lvl),
        .st      (st),
        .active  (active),
        .cyc_inc (cyc_inc),
        .restart (restart)
    );

    acq_counters #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ev_clr),
        .wr_en    (wr_en),
        .cyc_inc  (cyc_inc),
        .wr_ptr   (wr_ptr),
        .time_cnt (time_cnt),
        .cyc_cnt  (cyc_cnt),
        .wrap_hit (wrap_hit)
    );

    acq_regs #(.THW(THW), .PW(PW), .TW(TW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .st          (st),
        .clr_evt     (ev_clr),
        .set_wrap    (wrap_hit),
        .set_restart (restart),
        .wr_ptr      (wr_ptr),
        .time_cnt    (time_cnt),
        .cyc_cnt     (cyc_cnt),
        .sw_go       (sw_go),
        .sw_halt     (sw_halt),
        .sw_clr      (sw_clr),
        .sw_veto     (sw_veto),
        .supp_en     (supp_en),
        .thresh      (thresh),
        .err_q       (err_q),
        .err_clr     (err_clr),
        .reg_rdata   (reg_rdata)
    );

endmodule

// File: rtl/acq_run_ctrl_chk.sv
module acq_run_ctrl_chk
    import acq_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int TW    = 16,
    parameter int CW    = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [PW-1:0] wr_ptr,
    input logic [TW-1:0] time_cnt,
    input logic          veto_lvl,
    input logic          ev_go,
    input logic          ev_halt,
    input logic          ev_clr,
    input run_state_e    st,
    input logic [1:0]    err_q,
    input logic [1:0]    err_clr,
    input logic [CW-1:0] cyc_cnt
);

    localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CYCMAX = {CW{1'b1}};

    p_veto_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!veto_lvl && st != ST_IDLE));

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr != LAST) |=> wr_ptr == PW'($past(wr_ptr) + 1'b1));

    p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == LAST) |=> (wr_ptr == '0 && err_q[0]));

    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ev_clr) |=> $stable(wr_ptr));

    p_time_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_clr |=> time_cnt == TW'($past(time_cnt) + 1'b1));

    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clr |=> (time_cnt == '0 && wr_ptr == '0 && cyc_cnt == '0 &&
                    err_q == 2'b00 && st == ST_IDLE));

    p_halt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_halt |=> st == ST_IDLE);

    p_wrap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[0] && !ev_clr && !err_clr[0]) |=> err_q[0]);

    p_rst_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[1] && !ev_clr && !err_clr[1]) |=> err_q[1]);

    p_restart_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_go && !ev_halt && !ev_clr && st != ST_IDLE) |=> (err_q[1] && $stable(cyc_cnt)));

    p_run_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_go && !ev_halt && !ev_clr && st == ST_IDLE && cyc_cnt != CYCMAX)
        |=> cyc_cnt == CW'($past(cyc_cnt) + 1'b1));

endmodule

bind acq_run_ctrl acq_run_ctrl_chk #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .time_cnt (time_cnt),
    .veto_lvl (veto_lvl),
    .ev_go    (ev_go),
    .ev_halt  (ev_halt),
    .ev_clr   (ev_clr),
    .st       (st),
    .err_q    (err_q),
    .err_clr  (err_clr),
    .cyc_cnt  (cyc_cnt)
);

// File: tb/acq_run_ctrl_tb_top.sv
module acq_run_ctrl_tb_top;

    localparam int DEPTH = 12;
    localparam int TW    = 16;
    localparam int CW    = 3;
    localparam int THW   = 8;
    localparam int PW    = $clog2(DEPTH);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           fp_start = 1'b0, fp_stop = 1'b0, fp_veto = 1'b0, fp_reset = 1'b0;
    logic           data_valid = 1'b0;
    logic           reg_wr = 1'b0;
    logic [1:0]     reg_addr = 2'd1;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           wr_en;
    logic [PW-1:0]  wr_ptr;
    logic [TW-1:0]  time_cnt;
    logic           cnt_clr;
    logic           supp_en;
    logic [THW-1:0] thresh;

    acq_run_ctrl #(.DEPTH(DEPTH), .TW(TW), .CW(CW), .THW(THW)) dut_i (
        .clk(clk), .rst_n(rst_n), .fp_start(fp_start), .fp_stop(fp_stop),
        .fp_veto(fp_veto), .fp_reset(fp_reset), .data_valid(data_valid),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .time_cnt(time_cnt), .cnt_clr(cnt_clr), .supp_en(supp_en), .thresh(thresh)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit in_reset = 1'b1;
    bit done = 1'b0;

    // reference model state: 0 idle, 1 run, 2 inhibit
    int m_st, m_ptr, m_time, m_cyc, m_thr;
    bit m_ew, m_er, m_veto, m_supp, q_s, q_p, q_r;
    int cfg_thr = 0;
    bit cfg_supp = 0, cfg_veto = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void events(output bit g, output bit h, output bit c);
        bit cw;
        cw = reg_wr && reg_addr == 2'd0;
        g = (fp_start && !q_s) || (cw && reg_wdata[0]);
        h = (fp_stop  && !q_p) || (cw && reg_wdata[1]);
        c = (fp_reset && !q_r) || (cw && reg_wdata[2]);
    endfunction

    task automatic compare();
        bit g, h, c, we;
        logic [31:0] e_rd;
        string rq;
        events(g, h, c);
        we = data_valid && m_st != 0 && !(fp_veto || m_veto) && !c;
        rq = in_reset ? "R1" : "";
        chk(in_reset ? "R1" : "R4", "wr_en", wr_en, we);
        chk(in_reset ? "R1" : "R7", "wr_ptr", wr_ptr, m_ptr);
        chk(in_reset ? "R1" : "R5", "time_cnt", time_cnt, m_time);
        chk(in_reset ? "R1" : "R6", "cnt_clr", cnt_clr, c);
        chk(in_reset ? "R1" : "R10", "supp_en", supp_en, m_supp);
        chk(in_reset ? "R1" : "R10", "thresh", thresh, m_thr);
        case (reg_addr)
            2'd0: begin
                e_rd = 32'(m_thr) << 8 | 32'(m_supp) << 4 | 32'(m_veto) << 3;
                chk(in_reset ? "R1" : "R10", "ctrl read", reg_rdata, e_rd);
            end
            2'd1: begin
                chk(in_reset ? "R1" : "R3", "status state", reg_rdata[1:0], m_st);
                chk(in_reset ? "R1" : "R7", "status wrap flag", reg_rdata[4], m_ew);
                chk(in_reset ? "R1" : "R8", "status restart flag", reg_rdata[5], m_er);
                chk(in_reset ? "R1" : "R2", "status run count", reg_rdata[31:16], m_cyc);
                chk(in_reset ? "R1" : "R11", "status spare", {reg_rdata[15:6], reg_rdata[3:2]}, 0);
            end
            2'd2: chk(in_reset ? "R1" : "R11", "wptr read", reg_rdata, m_ptr);
            default: chk(in_reset ? "R1" : "R11", "time read", reg_rdata, m_time);
        endcase
        if (rq == "x") $display("never");
    endtask

    task automatic update();
        bit g, h, c, we, vt, sw, sr;
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_time = 0; m_cyc = 0; m_thr = 0;
            m_ew = 0; m_er = 0; m_veto = 0; m_supp = 0;
            q_s = 0; q_p = 0; q_r = 0;
            return;
        end
        events(g, h, c);
        vt = fp_veto || m_veto;
        we = data_valid && m_st != 0 && !vt && !c;
        if (c) begin
            m_time = 0; m_ptr = 0; m_cyc = 0; m_ew = 0; m_er = 0; m_st = 0;
        end else begin
            sw = we && m_ptr == DEPTH - 1;
            sr = g && !h && m_st != 0;
            m_time = (m_time + 1) % (1 << TW);
            if (we) m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
            if (reg_wr && reg_addr == 2'd1) begin
                if (reg_wdata[4]) m_ew = 0;
                if (reg_wdata[5]) m_er = 0;
            end
            if (sw) m_ew = 1;
            if (sr) m_er = 1;
            case (m_st)
                0: if (g && !h) begin
                    m_st = vt ? 2 : 1;
                    if (m_cyc < (1 << CW) - 1) m_cyc++;
                end
                1: if (h) m_st = 0; else if (vt) m_st = 2;
                default: if (h) m_st = 0; else if (!vt) m_st = 1;
            endcase
        end
        if (reg_wr && reg_addr == 2'd0) begin
            m_veto = reg_wdata[3];
            m_supp = reg_wdata[4];
            m_thr  = int'(reg_wdata[15:8]);
        end
        q_s = fp_start; q_p = fp_stop; q_r = fp_reset;
    endtask

    task automatic step();
        #1;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic sw_cmd(input logic [2:0] bits);
        reg_wr = 1'b1; reg_addr = 2'd0;
        reg_wdata = 32'(cfg_thr) << 8 | 32'(cfg_supp) << 4 | 32'(cfg_veto) << 3 | 32'(bits);
        step();
        reg_wr = 1'b0; reg_addr = 2'd1; reg_wdata = '0;
    endtask

    task automatic w1c(input logic [1:0] mask);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'(mask) << 4;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        update();
        @(negedge clk);
        idle(3);                         // R1 reset values
        rst_n = 1'b1; in_reset = 1'b0;
        idle(2);

        cfg_thr = 8'hA5; cfg_supp = 1; // R10 settings
        sw_cmd(3'b000);
        idle(1);

        data_valid = 1'b1;
        fp_start = 1'b1; idle(3);        // R12 held line, single go, R2
        fp_start = 1'b0; idle(2);

        fp_veto = 1'b1; idle(3);         // R4 front-panel veto
        fp_veto = 1'b0; idle(2);
        cfg_veto = 1; sw_cmd(3'b000); idle(2);   // R4 software veto
        cfg_veto = 0; sw_cmd(3'b000); idle(1);

        sw_cmd(3'b001); idle(1);         // R8 go while running
        w1c(2'b10); idle(1);             // R9 write-one clear
        fp_start = 1'b1;                 // R9 set and clear in one cycle
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h20;
        step();
        reg_wr = 1'b0; reg_wdata = '0; fp_start = 1'b0;
        idle(1);
        w1c(2'b10);

        idle(14);                        // R7 pointer wrap
        reg_addr = 2'd2; idle(1); reg_addr = 2'd1;
        w1c(2'b01);

        fp_stop = 1'b1; idle(2); fp_stop = 1'b0; idle(2);    // R3 stop
        fp_start = 1'b1; fp_stop = 1'b1; idle(1);            // R3 halt wins
        fp_start = 1'b0; fp_stop = 1'b0; idle(2);

        fp_veto = 1'b1; sw_cmd(3'b001); idle(2);             // R2 go into inhibit
        fp_veto = 1'b0; idle(2);
        sw_cmd(3'b010); idle(1);

        for (int k = 0; k < 9; k++) begin                    // R2 saturation
            sw_cmd(3'b001); idle(1); sw_cmd(3'b010);
        end

        sw_cmd(3'b001); idle(2);
        fp_reset = 1'b1; idle(2); fp_reset = 1'b0; idle(2);  // R6 front-panel clear
        sw_cmd(3'b001); idle(3);
        sw_cmd(3'b101); idle(2);                             // R6 clear beats go

        for (int a = 0; a < 4; a++) begin                    // R11 read map
            reg_addr = 2'(a); idle(1);
        end
        reg_addr = 2'd1;

        sw_cmd(3'b001);
        for (int k = 0; k < 10; k++) begin
            data_valid = k[0]; idle(1);
        end
        data_valid = 1'b0;
        idle(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule